// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into a stream of single-cycle strobes at sixteen times a serial line's bit rate. The programmed divisor has two parts: a 16-bit whole number of clock cycles per strobe and a 6-bit fraction in 1/64 steps. The fraction is the fractional part of clock / (16 x baud), times 64 and rounded to the nearest integer. Because the fraction is kept in an accumulator rather than rounded away, the average strobe period equals the full non-integer divisor. For example, a 50 MHz clock at 115200 baud needs 27.1267, which is programmed as whole part 27 and fraction 8 and gives an average of 27.125 cycles. An 8 MHz clock at 19200 baud needs about 26.04, programmed as 26 and 3. Both errors are far inside the 5 percent mismatch that a receiver can tolerate.

A second output strobes once for every sixteen oversampling strobes, in the same cycle as the sixteenth, and marks bit boundaries for a transmitter. Software works out the two divisor fields. The block only consumes them. There is no data stream here, so every pin is a plain control or status level, with no valid/ready handshake.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tick16` and `tick_bit` are both low.
- R2: With `enable` high and `div_int` = D >= 1 held constant, consecutive `tick16` pulses are exactly D or D+1 clock cycles apart.
- R3: After every `tick16`, a 6-bit accumulator adds `div_frac` = F modulo 64. An overflow stretches the following period by one cycle. So 64 consecutive periods starting at the first tick after a restart total exactly 64*D + F cycles.
- R4: The first `tick16` after a restart comes D cycles after the restart clock edge. That first period is never stretched.
- R5: When `div_int` is 0, no `tick16` or `tick_bit` is produced.
- R6: When `enable` is low, no strobes are produced and the period counter, accumulator and bit counter are cleared.
- R7: Any change to `div_int` or `div_frac` restarts the counter, accumulator and bit counter on the next clock edge. The first tick then follows R4.
- R8: `tick_bit` pulses for one cycle together with every 16th `tick16` counted from a restart, and never in any other cycle.
- R9: For D >= 2 with the divisor held, `tick16` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high. Low holds it cleared |
| div_int | input | 16 | Whole clock cycles per 16x strobe. 0 stops the generator |
| div_frac | input | 6 | Extra fraction of a cycle per strobe, in units of 1/64 |
| tick16 | output | 1 | One-cycle strobe at 16x the bit rate |
| tick_bit | output | 1 | One-cycle strobe on every 16th `tick16` |

## Verification
The bench sweeps divisor pairs from the extremes (1/0, 1/63, 2/1, 100/0) to the two realistic settings. Over 64 periods it checks the exact cycle total and the size of each gap. An accumulator that drops its carry, stretches the wrong period or wraps at the wrong width shows up as a wrong total or as a gap outside D..D+1. Directed tests change the whole part and the fraction part separately in the middle of a period. A design that ignores the change, or keeps its old count or accumulator, puts the first tick in the wrong cycle. Further directed tests cover a zero divisor, a disabled block and the alignment of the bit strobe on the sixteenth tick. A miscounted bit divider or a free-running counter shows up there.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 6;
  localparam int unsigned DEF_OVERSMP = 16;
endpackage

// File: rtl/baud_restart_ctl.sv
module baud_restart_ctl #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              restart
);
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      int_q  <= div_int;
      frac_q <= div_frac;
    end
  end

  assign restart = !enable || (div_int == '0) ||
                   (div_int != int_q) || (div_frac != frac_q);
endmodule

// File: rtl/baud_frac_period.sv
module baud_frac_period #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              strobe,
  output logic              tick
);
  logic [INT_W-1:0]  cnt;
  logic [INT_W-1:0]  target;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum    = {1'b0, acc} + {1'b0, div_frac};
  assign strobe = !restart && (cnt == target);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt    <= '0;
      acc    <= '0;
      target <= div_int - INT_W'(1);
      tick   <= 1'b0;
    end else if (strobe) begin
      cnt    <= '0;
      acc    <= sum[FRAC_W-1:0];
      target <= div_int - INT_W'(1) + INT_W'(sum[FRAC_W]);
      tick   <= 1'b1;
    end else begin
      cnt    <= cnt + INT_W'(1);
      tick   <= 1'b0;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && acc == '0 && !tick)); // R7

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && $past(!restart) && $stable(div_int)) |->
      (target == div_int - INT_W'(1) || target == div_int)); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int > INT_W'(1) && $stable(div_int)) |=> !tick); // R9
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned OVERSMP = baud_pkg::DEF_OVERSMP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic strobe,
  output logic tick_bit
);
  localparam int unsigned SUB_W = $clog2(OVERSMP);
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sub      <= '0;
      tick_bit <= 1'b0;
    end else if (strobe) begin
      sub      <= (sub == SUB_W'(OVERSMP - 1)) ? '0 : sub + SUB_W'(1);
      tick_bit <= (sub == SUB_W'(OVERSMP - 1));
    end else begin
      tick_bit <= 1'b0;
    end
  end

  AST_BIT_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |=> !tick_bit); // R8
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int unsigned INT_W   = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W  = baud_pkg::DEF_FRAC_W,
  parameter int unsigned OVERSMP = baud_pkg::DEF_OVERSMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick16,
  output logic              tick_bit
);
  logic restart;
  logic strobe;

  baud_restart_ctl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_restart (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .div_int(div_int), .div_frac(div_frac), .restart(restart)
  );

  baud_frac_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .div_int(div_int), .div_frac(div_frac),
    .strobe(strobe), .tick(tick16)
  );

  baud_bit_div #(.OVERSMP(OVERSMP)) u_bitdiv (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .strobe(strobe), .tick_bit(tick_bit)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || div_int == '0) |=> (!tick16 && !tick_bit)); // R5 R6

  AST_BIT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |-> tick16); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!tick16 && !tick_bit)); // R1
endmodule

// File: tb/baud_frac_gen_bench.sv
module baud_frac_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        tick16, tick_bit;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  baud_frac_gen u_baud_frac_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .div_int(div_int), .div_frac(div_frac),
    .tick16(tick16), .tick_bit(tick_bit)
  );

  // {D, F, expected cycles over 64 periods = 64*D+F}
  localparam int NVEC = 7;
  localparam int VEC [NVEC][3] = '{
    '{27, 8, 1736}, '{26, 3, 1667}, '{1, 0, 64}, '{1, 63, 127},
    '{5, 32, 352}, '{100, 0, 6400}, '{2, 1, 129}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycles (negedges) from now until first tick16, limit-bounded
  task automatic first_tick(input int limit, output int k);
    k = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (tick16 && k < 0) k = c;
    end
  endtask

  task automatic count_ticks(input int n, output int t, output int b);
    t = 0; b = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (tick16) t++;
      if (tick_bit) b++;
    end
  endtask

  initial begin
    #2_000_000;
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, t, b;
    // R1: reset state
    div_int = 16'd4; enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tick16 && !tick_bit, "R1", "outputs in reset", int'(tick16) + int'(tick_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tick16 && !tick_bit, "R1", "outputs after reset", int'(tick16) + int'(tick_bit), 0);

    // Vector loop: R2 R3 R4 R8
    for (int i = 0; i < NVEC; i++) begin
      int d, f, cyc, ticks, last, t1, gapbad, bits, firstbit, misal;
      d = VEC[i][0]; f = VEC[i][1];
      @(negedge clk); enable = 1'b0; div_int = 16'(d); div_frac = 6'(f);
      @(negedge clk); enable = 1'b1;
      cyc = 0; ticks = 0; last = 0; t1 = 0; gapbad = 0; bits = 0;
      firstbit = -1; misal = 0;
      while (ticks < 65) begin
        @(negedge clk); cyc++;
        if (tick_bit) begin
          bits++;
          if (!tick16) misal++;
          if (firstbit < 0) firstbit = ticks + 1;
        end
        if (tick16) begin
          ticks++;
          if (ticks == 1) t1 = cyc;
          else if (cyc - last != d && cyc - last != d + 1) gapbad++;
          last = cyc;
        end
      end
      chk(t1 == d, "R4", "first tick latency", t1, d);
      chk(gapbad == 0, "R2", "gaps outside D..D+1", gapbad, 0);
      chk(last - t1 == VEC[i][2], "R3", "64-period span", last - t1, VEC[i][2]);
      chk(firstbit == 16, "R8", "first bit tick index", firstbit, 16);
      chk(bits == 4 && misal == 0, "R8", "bit ticks in 65 ticks", bits * 100 + misal, 400);
    end

    // R5: zero divisor
    @(negedge clk); div_int = 16'd0; div_frac = 6'd5; enable = 1'b1;
    count_ticks(100, t, b);
    chk(t == 0 && b == 0, "R5", "ticks with zero divisor", t + b, 0);

    // R6: disabled, then restart on enable
    @(negedge clk); div_int = 16'd3; div_frac = 6'd0; enable = 1'b0;
    count_ticks(100, t, b);
    chk(t == 0 && b == 0, "R6", "ticks while disabled", t + b, 0);
    @(negedge clk); enable = 1'b1;
    first_tick(10, k);
    chk(k == 3, "R6", "first tick after enable", k, 3);

    // R7: whole-part change mid-period
    @(negedge clk); div_int = 16'd50;
    repeat (30) @(negedge clk);
    div_int = 16'd10;
    first_tick(15, k);
    chk(k == 11, "R7", "tick after whole-part change", k, 11);
    // R7: fraction-only change mid-period
    repeat (5) @(negedge clk);
    div_frac = 6'd5;
    first_tick(15, k);
    chk(k == 11, "R7", "tick after fraction change", k, 11);

    // R9: single-cycle pulses at D=2
    @(negedge clk); div_int = 16'd2; div_frac = 6'd0;
    begin
      int dbl; bit prev;
      dbl = 0; prev = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (tick16 && prev) dbl++;
        prev = tick16;
      end
      chk(dbl == 0, "R9", "back-to-back ticks", dbl, 0);
    end

    // R1: reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    count_ticks(5, t, b);
    chk(t == 0 && b == 0, "R1", "ticks during mid-run reset", t + b, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule